// File: doc/BRIEF.md
# CAN Error Counter and Bus-Off Manager

This block holds the receive and transmit error counters of a CAN controller. It also decides when the node goes bus-off and how it comes back. A protocol engine elsewhere sends it counting strobes: receive +1, receive +8, receive −1, transmit +8 and transmit −1. It also sends a bit-time strobe together with the sampled bus level, where 1 means recessive. The block answers with these signals:

- the bus-off flag;
- the error-warning and error-passive status;
- single-cycle interrupt pulses on status changes;
- a one-cycle request that forces the controller into reset mode;
- a flag saying the node may take part in bus traffic.

Software sees three byte registers through a simple write/read port: the warning limit, the receive count and the transmit count. It can change them only while the reset-mode input is high. A written value is acted on only once reset mode is released. Writing 255 to the transmit count starts a bus-off. Writing any other value during bus-off ends the bus-off state.

Bus-off recovery needs bus-free periods of 11 consecutive recessive bits. Each one lowers the transmit count by one, starting from 127, so recovery ends after 128 periods. Counting happens only while reset mode is low.

Top module: `can_errcnt_busoff`

## Requirements
- R1: After a hardware reset both counters read 0, the warning limit reads 96, and bus-off, warning, passive, the interrupt pulses and the force request are all 0.
- R2: Register addresses are decoded as follows: 13 is the warning limit, 14 the receive count and 15 the transmit count. Any other address reads 0. Writes change a register only while reset mode is high; in operating mode they are ignored.
- R3: Outside reset mode and bus-off, the counting strobes act as follows:
  - receive +8 takes priority over receive +1, which takes priority over receive −1;
  - the receive count saturates at 255;
  - transmit +8 takes priority over transmit −1;
  - every decrement stops at 0.
  While reset mode or bus-off is active, all counting strobes are ignored.
- R4: The warning status is set when either count is greater than or equal to the limit, or when bus-off is active. The passive status is set when either count is 128 or more, or when bus-off is active. Both status bits follow the counters one clock later and do not change while reset mode is high.
- R5: Each change of the warning status, or of the passive status, gives a one-cycle pulse on its own interrupt output, in the same cycle the status changes. No pulse is given while reset mode is high.
- R6: A transmit +8 that would take the count past 255 starts a bus-off on the same clock edge. That edge sets bus-off, loads the transmit count with 127, clears the receive count and gives a one-cycle force-reset pulse.
- R7: A bus-free period is 11 consecutive bit strobes that sample recessive. A dominant sample restarts the run. The run is cleared while reset mode is high.
- R8: During bus-off with reset mode low, each bus-free period lowers the transmit count by one. The period that arrives at count 0 ends bus-off, so recovery takes 128 periods. While reset mode is high the count is frozen.
- R9: A write to the receive count during bus-off is ignored.
- R10: During bus-off, a write of 0 to 254 to the transmit count clears bus-off at once. After any release of reset mode, the online flag stays low until one bus-free period has been seen.
- R11: A write of 255 to the transmit count leaves bus-off low while reset mode remains high. The clock edge at which reset mode is seen low starts a bus-off exactly as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_mode_i | input | 1 | Controller reset mode (1 = reset mode) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for write and read |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| rx_inc1_i | input | 1 | Receive count +1 |
| rx_inc8_i | input | 1 | Receive count +8 |
| rx_dec_i | input | 1 | Receive count −1 |
| tx_inc8_i | input | 1 | Transmit count +8 |
| tx_dec_i | input | 1 | Transmit count −1 |
| bit_tick_i | input | 1 | One-cycle strobe per sampled bit |
| bus_level_i | input | 1 | Sampled bus level, 1 = recessive |
| bus_off_o | output | 1 | Bus-off state |
| err_warn_o | output | 1 | Error-warning status |
| err_passive_o | output | 1 | Error-passive status |
| irq_warn_o | output | 1 | Pulse on warning status change |
| irq_passive_o | output | 1 | Pulse on passive status change |
| force_reset_o | output | 1 | Pulse requesting reset mode on bus-off entry |
| online_o | output | 1 | Node may take part in bus traffic |

## Verification
The results appear at these points after the stimulus:

- Counter and register results can be read back one clock edge after the strobe or write.
- Bus-off and the force request change on that same edge.
- Warning and passive status, and their interrupt pulses, change one edge later.
- The online flag rises on the edge that samples the eleventh recessive bit.

The bench drives every input just after a falling edge and samples just after the next falling edge. For status it waits one further falling edge, so it checks that the status has not yet moved in the first cycle and has moved in the second. The status thresholds are swept over every counter value for several warning limits, and the expected bits are computed arithmetically.

// File: rtl/can_ec_pkg.sv
// Shared constants and types for the CAN error counter block.
// Assumes byte-wide registers and an 8-bit register address.
package can_ec_pkg;
    localparam int CNT_W  = 8;
    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] ADDR_EWL = 8'd13;
    localparam logic [REG_AW-1:0] ADDR_RXC = 8'd14;
    localparam logic [REG_AW-1:0] ADDR_TXC = 8'd15;

    localparam logic [CNT_W-1:0] BUSOFF_TX_LOAD = 8'd127;
    localparam logic [CNT_W-1:0] PASSIVE_LVL    = 8'd128;
    localparam logic [CNT_W-1:0] CNT_MAX        = '1;

    // Counting strobes from the protocol engine
    typedef struct packed {
        logic rx_inc1;
        logic rx_inc8;
        logic rx_dec;
        logic tx_inc8;
        logic tx_dec;
    } err_evt_t;
endpackage

// File: rtl/can_ec_busfree.sv
// Bus-free detector: raises free_o for one cycle on the bit strobe that
// completes RUN_LEN consecutive recessive samples. A dominant sample
// restarts the run; hold_i keeps the run cleared.
// Assumes tick_i is a single-cycle strobe per bit.
module can_ec_busfree #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic tick_i,
    input  logic recessive_i,
    output logic free_o
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

    logic [RW-1:0] run_q;

    assign free_o = !hold_i && tick_i && recessive_i && (run_q == LAST);

    // Count the current run of recessive samples
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            run_q <= '0;
        end else if (tick_i) begin
            if (!recessive_i || free_o) run_q <= '0;
            else                        run_q <= run_q + RW'(1);
        end
    end
endmodule

// File: rtl/can_ec_counters.sv
// Error counters, warning-limit register and bus-off sequencing.
// Assumes the caller masks nothing: writes are gated by reset mode here,
// strobes are ignored in reset mode and during bus-off.
module can_ec_counters
    import can_ec_pkg::*;
#(
    parameter logic [CNT_W-1:0] EWL_INIT = 8'd96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_mode_i,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  err_evt_t          evt_i,
    input  logic              bus_free_i,
    output logic [CNT_W-1:0]  rxc_o,
    output logic [CNT_W-1:0]  txc_o,
    output logic [CNT_W-1:0]  ewl_o,
    output logic              bus_off_o,
    output logic              force_reset_o,
    output logic              sync_wait_o
);
    logic [CNT_W-1:0] rxc_q, txc_q, ewl_q;
    logic             bus_off_q, force_q, sync_q, mode_q;
    logic             active, leave, tx_ovf, force_ent, enter, wr_ok;
    logic [CNT_W:0]   rx_p8, rx_p1, tx_p8;

    assign active    = !reset_mode_i && !bus_off_q;
    assign leave     = mode_q && !reset_mode_i;
    assign rx_p8     = {1'b0, rxc_q} + (CNT_W+1)'(8);
    assign rx_p1     = {1'b0, rxc_q} + (CNT_W+1)'(1);
    assign tx_p8     = {1'b0, txc_q} + (CNT_W+1)'(8);
    assign tx_ovf    = active && evt_i.tx_inc8 && tx_p8[CNT_W];
    assign force_ent = leave && (txc_q == CNT_MAX);
    assign enter     = tx_ovf || force_ent;
    assign wr_ok     = reset_mode_i && wr_en_i;

    // Remember the mode so the release edge can be detected
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b1;
        else        mode_q <= reset_mode_i;
    end

    // Force-reset request pulse on bus-off entry
    always_ff @(posedge clk) begin
        if (!rst_n) force_q <= 1'b0;
        else        force_q <= enter;
    end

    // Wait-for-bus-free flag after any reset-mode period
    always_ff @(posedge clk) begin
        if (!rst_n || reset_mode_i) sync_q <= 1'b1;
        else if (bus_free_i)        sync_q <= 1'b0;
    end

    // Counters, limit and bus-off state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxc_q     <= '0;
            txc_q     <= '0;
            ewl_q     <= EWL_INIT;
            bus_off_q <= 1'b0;
        end else if (enter) begin
            bus_off_q <= 1'b1;
            txc_q     <= BUSOFF_TX_LOAD;
            rxc_q     <= '0;
        end else if (reset_mode_i) begin
            if (wr_ok && wr_addr_i == ADDR_EWL) ewl_q <= wr_data_i;
            if (wr_ok && wr_addr_i == ADDR_RXC && !bus_off_q) rxc_q <= wr_data_i;
            if (wr_ok && wr_addr_i == ADDR_TXC) begin
                txc_q <= wr_data_i;
                if (bus_off_q && wr_data_i != CNT_MAX) bus_off_q <= 1'b0;
            end
        end else if (bus_off_q) begin
            if (bus_free_i) begin
                if (txc_q == '0) bus_off_q <= 1'b0;
                else             txc_q     <= txc_q - CNT_W'(1);
            end
        end else begin
            if (evt_i.rx_inc8)                 rxc_q <= rx_p8[CNT_W] ? CNT_MAX : rx_p8[CNT_W-1:0];
            else if (evt_i.rx_inc1)            rxc_q <= rx_p1[CNT_W] ? CNT_MAX : rx_p1[CNT_W-1:0];
            else if (evt_i.rx_dec && rxc_q != '0) rxc_q <= rxc_q - CNT_W'(1);
            if (evt_i.tx_inc8)                 txc_q <= tx_p8[CNT_W-1:0];
            else if (evt_i.tx_dec && txc_q != '0) txc_q <= txc_q - CNT_W'(1);
        end
    end

    assign rxc_o         = rxc_q;
    assign txc_o         = txc_q;
    assign ewl_o         = ewl_q;
    assign bus_off_o     = bus_off_q;
    assign force_reset_o = force_q;
    assign sync_wait_o   = sync_q;
endmodule

// File: rtl/can_ec_status.sv
// Warning and passive status with change-interrupt pulses.
// Status is sampled from the counters one clock late and frozen while
// hold_i (reset mode) is high, so software-written values take effect
// only after release.
module can_ec_status
    import can_ec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] rxc_i,
    input  logic [CNT_W-1:0] txc_i,
    input  logic [CNT_W-1:0] ewl_i,
    input  logic             bus_off_i,
    output logic             warn_o,
    output logic             passive_o,
    output logic             irq_warn_o,
    output logic             irq_passive_o
);
    logic warn_c, passive_c;
    logic warn_q, passive_q, irq_w_q, irq_p_q;

    assign warn_c    = bus_off_i || (rxc_i >= ewl_i) || (txc_i >= ewl_i);
    assign passive_c = bus_off_i || (rxc_i >= PASSIVE_LVL) || (txc_i >= PASSIVE_LVL);

    // Sample status and flag its changes outside reset mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_q    <= 1'b0;
            passive_q <= 1'b0;
            irq_w_q   <= 1'b0;
            irq_p_q   <= 1'b0;
        end else if (hold_i) begin
            irq_w_q   <= 1'b0;
            irq_p_q   <= 1'b0;
        end else begin
            warn_q    <= warn_c;
            passive_q <= passive_c;
            irq_w_q   <= warn_c != warn_q;
            irq_p_q   <= passive_c != passive_q;
        end
    end

    assign warn_o        = warn_q;
    assign passive_o     = passive_q;
    assign irq_warn_o    = irq_w_q;
    assign irq_passive_o = irq_p_q;
endmodule

// File: rtl/can_errcnt_busoff.sv
// Top level: CAN error counters, status and bus-off manager.
// Assumes a single clock, synchronous active-low reset and strobes
// that last one cycle. Register reads are combinational.
module can_errcnt_busoff
    import can_ec_pkg::*;
#(
    parameter int               BUSFREE_BITS = 11,
    parameter logic [CNT_W-1:0] EWL_INIT     = 8'd96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_mode_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o,
    input  logic              rx_inc1_i,
    input  logic              rx_inc8_i,
    input  logic              rx_dec_i,
    input  logic              tx_inc8_i,
    input  logic              tx_dec_i,
    input  logic              bit_tick_i,
    input  logic              bus_level_i,
    output logic              bus_off_o,
    output logic              err_warn_o,
    output logic              err_passive_o,
    output logic              irq_warn_o,
    output logic              irq_passive_o,
    output logic              force_reset_o,
    output logic              online_o
);
    err_evt_t         evt;
    logic             bus_free, sync_wait, bus_off;
    logic [CNT_W-1:0] rxc, txc, ewl;

    assign evt = '{rx_inc1: rx_inc1_i, rx_inc8: rx_inc8_i, rx_dec: rx_dec_i,
                   tx_inc8: tx_inc8_i, tx_dec: tx_dec_i};

    can_ec_busfree #(.RUN_LEN(BUSFREE_BITS)) u_free (
        .clk(clk), .rst_n(rst_n), .hold_i(reset_mode_i),
        .tick_i(bit_tick_i), .recessive_i(bus_level_i), .free_o(bus_free)
    );

    can_ec_counters #(.EWL_INIT(EWL_INIT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .reset_mode_i(reset_mode_i),
        .wr_en_i(reg_wr_i), .wr_addr_i(reg_addr_i), .wr_data_i(reg_wdata_i),
        .evt_i(evt), .bus_free_i(bus_free),
        .rxc_o(rxc), .txc_o(txc), .ewl_o(ewl), .bus_off_o(bus_off),
        .force_reset_o(force_reset_o), .sync_wait_o(sync_wait)
    );

    can_ec_status u_stat (
        .clk(clk), .rst_n(rst_n), .hold_i(reset_mode_i),
        .rxc_i(rxc), .txc_i(txc), .ewl_i(ewl), .bus_off_i(bus_off),
        .warn_o(err_warn_o), .passive_o(err_passive_o),
        .irq_warn_o(irq_warn_o), .irq_passive_o(irq_passive_o)
    );

    // Register read decode
    always_comb begin
        case (reg_addr_i)
            ADDR_EWL: reg_rdata_o = ewl;
            ADDR_RXC: reg_rdata_o = rxc;
            ADDR_TXC: reg_rdata_o = txc;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign bus_off_o = bus_off;
    assign online_o  = !reset_mode_i && !bus_off && !sync_wait;
endmodule

// File: rtl/can_ec_chk.sv
// Checker bound to the top: temporal properties over ports and the
// counter state between the counter and status pieces.
module can_ec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reset_mode_i,
    input logic       reg_wr_i,
    input logic [7:0] reg_addr_i,
    input logic       tx_inc8_i,
    input logic       tx_dec_i,
    input logic       bit_tick_i,
    input logic       bus_level_i,
    input logic [7:0] rxc,
    input logic [7:0] txc,
    input logic [7:0] ewl,
    input logic       bus_off,
    input logic       err_warn_o,
    input logic       irq_warn_o,
    input logic       force_reset_o,
    input logic       online_o
);
    p_ewl_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_mode_i && reg_wr_i && reg_addr_i == 8'd13) |=> $stable(ewl));

    p_tx_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_mode_i && !bus_off && tx_dec_i && !tx_inc8_i && txc == 8'd0) |=> txc == 8'd0);

    p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_mode_i |=> ($stable(err_warn_o) && !irq_warn_o));

    p_irq_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_warn_o |-> (err_warn_o != $past(err_warn_o)));

    p_busoff_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off) |-> (txc == 8'd127 && rxc == 8'd0 && force_reset_o));

    p_recovery_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_off) && !$past(reset_mode_i)) |-> $past(txc) == 8'd0);

    p_rx_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_mode_i && bus_off && reg_wr_i && reg_addr_i == 8'd14) |=> $stable(rxc));

    p_online_after_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(online_o) |-> $past(bit_tick_i && bus_level_i));
endmodule

bind can_errcnt_busoff can_ec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reset_mode_i(reset_mode_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .tx_inc8_i(tx_inc8_i), .tx_dec_i(tx_dec_i),
    .bit_tick_i(bit_tick_i), .bus_level_i(bus_level_i),
    .rxc(rxc), .txc(txc), .ewl(ewl), .bus_off(bus_off),
    .err_warn_o(err_warn_o), .irq_warn_o(irq_warn_o),
    .force_reset_o(force_reset_o), .online_o(online_o)
);

// File: tb/tb_can_errcnt_busoff.sv
`timescale 1ns/1ps
module tb_can_errcnt_busoff;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reset_mode_i = 1'b1;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       rx_inc1_i = 1'b0, rx_inc8_i = 1'b0, rx_dec_i = 1'b0;
    logic       tx_inc8_i = 1'b0, tx_dec_i = 1'b0;
    logic       bit_tick_i = 1'b0, bus_level_i = 1'b1;
    logic       bus_off_o, err_warn_o, err_passive_o;
    logic       irq_warn_o, irq_passive_o, force_reset_o, online_o;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    can_errcnt_busoff dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        reset_mode_i = m;
        step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        step();
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        reg_addr_i = a;
        #1;
        v = int'(reg_rdata_o);
    endtask

    // mask bits: {rx_inc1, rx_inc8, rx_dec, tx_inc8, tx_dec}
    task automatic evt(input logic [4:0] m);
        {rx_inc1_i, rx_inc8_i, rx_dec_i, tx_inc8_i, tx_dec_i} = m;
        step();
        {rx_inc1_i, rx_inc8_i, rx_dec_i, tx_inc8_i, tx_dec_i} = '0;
    endtask

    task automatic bitb(input logic lvl);
        bit_tick_i = 1'b1; bus_level_i = lvl;
        step();
        bit_tick_i = 1'b0; bus_level_i = 1'b1;
    endtask

    task automatic busfree();
        for (int i = 0; i < 11; i++) bitb(1'b1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        rd(13, v); chk("R1 ewl", v, 96);
        rd(14, v); chk("R1 rxc", v, 0);
        rd(15, v); chk("R1 txc", v, 0);
        chk("R1 bus_off", bus_off_o, 0);
        chk("R1 warn", err_warn_o, 0);
        chk("R1 passive", err_passive_o, 0);
        chk("R1 force", force_reset_o, 0);

        // R2: decode and write gating
        wr(14, 5); wr(15, 7); wr(13, 50);
        rd(14, v); chk("R2 rx write", v, 5);
        rd(15, v); chk("R2 tx write", v, 7);
        rd(13, v); chk("R2 ewl write", v, 50);
        rd(12, v); chk("R2 unmapped", v, 0);
        set_mode(1'b0);
        wr(14, 99); wr(13, 1); wr(15, 200);
        rd(14, v); chk("R2 rx locked", v, 5);
        rd(13, v); chk("R2 ewl locked", v, 50);
        rd(15, v); chk("R2 tx locked", v, 7);

        // R7 / R10: online waits for 11 recessive bits, dominant restarts
        chk("R10 offline after release", online_o, 0);
        for (int i = 0; i < 10; i++) bitb(1'b1);
        bitb(1'b0);
        for (int i = 0; i < 10; i++) bitb(1'b1);
        chk("R7 run restarted", online_o, 0);
        bitb(1'b1);
        chk("R7 bus free seen", online_o, 1);

        // R3: counting strobes
        evt(5'b10000); rd(14, v); chk("R3 rx +1", v, 6);
        evt(5'b01000); rd(14, v); chk("R3 rx +8", v, 14);
        evt(5'b00100); rd(14, v); chk("R3 rx -1", v, 13);
        evt(5'b11100); rd(14, v); chk("R3 rx priority", v, 21);
        evt(5'b00010); rd(15, v); chk("R3 tx +8", v, 15);
        evt(5'b00001); rd(15, v); chk("R3 tx -1", v, 14);
        evt(5'b00011); rd(15, v); chk("R3 tx priority", v, 22);
        set_mode(1'b1); wr(14, 0); wr(15, 0); set_mode(1'b0);
        evt(5'b00101);
        rd(14, v); chk("R3 rx floor", v, 0);
        rd(15, v); chk("R3 tx floor", v, 0);
        set_mode(1'b1); wr(14, 250); set_mode(1'b0);
        evt(5'b01000); rd(14, v); chk("R3 rx sat +8", v, 255);
        evt(5'b10000); rd(14, v); chk("R3 rx sat +1", v, 255);
        set_mode(1'b1);
        evt(5'b11010); rd(14, v); chk("R3 ignored in reset rx", v, 255);
        rd(15, v); chk("R3 ignored in reset tx", v, 0);

        // R4: threshold sweep over all counter values
        for (int e = 0; e < 5; e++) begin
            int lim;
            lim = (e == 0) ? 0 : (e == 1) ? 50 : (e == 2) ? 127 : (e == 3) ? 200 : 255;
            set_mode(1'b1); wr(13, 8'(lim));
            for (int c = 0; c < 256; c++) begin
                set_mode(1'b1); wr(14, 8'(c)); wr(15, 0); set_mode(1'b0);
                chk("R4 rx warn", err_warn_o, int'(c >= lim));
                chk("R4 rx passive", err_passive_o, int'(c >= 128));
            end
            for (int c = 0; c < 255; c++) begin
                set_mode(1'b1); wr(14, 0); wr(15, 8'(c)); set_mode(1'b0);
                chk("R4 tx warn", err_warn_o, int'(c >= lim));
                chk("R4 tx passive", err_passive_o, int'(c >= 128));
            end
        end

        // R4 hold in reset mode, R5 pulse on release
        set_mode(1'b1); wr(13, 96); wr(14, 0); wr(15, 0); set_mode(1'b0);
        step(); step();
        set_mode(1'b1); wr(14, 200); step(); step();
        chk("R4 warn held", err_warn_o, 0);
        chk("R5 no irq in reset", irq_warn_o, 0);
        set_mode(1'b0);
        chk("R4 warn after release", err_warn_o, 1);
        chk("R5 irq warn on release", irq_warn_o, 1);
        chk("R5 irq passive on release", irq_passive_o, 1);
        step();
        chk("R5 irq one cycle", irq_warn_o, 0);

        // R5: rising warn one cycle after the counter
        set_mode(1'b1); wr(14, 90); set_mode(1'b0); step(); step();
        evt(5'b01000);
        rd(14, v); chk("R5 rx now 98", v, 98);
        chk("R5 warn not yet", err_warn_o, 0);
        step();
        chk("R5 warn set", err_warn_o, 1);
        chk("R5 irq warn", irq_warn_o, 1);
        step();
        chk("R5 irq warn ends", irq_warn_o, 0);
        // passive rise
        set_mode(1'b1); wr(14, 125); set_mode(1'b0); step(); step();
        evt(5'b01000);
        chk("R5 passive not yet", err_passive_o, 0);
        step();
        chk("R5 passive set", err_passive_o, 1);
        chk("R5 irq passive", irq_passive_o, 1);
        step();
        chk("R5 irq passive ends", irq_passive_o, 0);
        // warn fall
        set_mode(1'b1); wr(14, 97); set_mode(1'b0); step(); step();
        evt(5'b00100); evt(5'b00100);
        step();
        chk("R5 warn cleared", err_warn_o, 0);
        chk("R5 irq on fall", irq_warn_o, 1);

        // R6: overflow bus-off
        set_mode(1'b1); wr(14, 40); wr(15, 250); set_mode(1'b0);
        evt(5'b00010);
        chk("R6 bus_off", bus_off_o, 1);
        chk("R6 force pulse", force_reset_o, 1);
        rd(15, v); chk("R6 tx load", v, 127);
        rd(14, v); chk("R6 rx clear", v, 0);
        evt(5'b10000);
        chk("R6 force one cycle", force_reset_o, 0);
        rd(14, v); chk("R3 ignored in bus-off", v, 0);
        chk("R6 warn", err_warn_o, 1);
        chk("R6 passive", err_passive_o, 1);

        // R9: rx write ignored in bus-off
        set_mode(1'b1); wr(14, 33);
        rd(14, v); chk("R9 rx write ignored", v, 0);

        // R8: recovery
        set_mode(1'b0); busfree();
        rd(15, v); chk("R8 first decrement", v, 126);
        set_mode(1'b1); busfree();
        rd(15, v); chk("R8 frozen in reset", v, 126);
        chk("R8 still bus-off", bus_off_o, 1);
        set_mode(1'b0);
        for (int i = 0; i < 126; i++) busfree();
        rd(15, v); chk("R8 reaches zero", v, 0);
        chk("R8 bus-off after 127", bus_off_o, 1);
        busfree();
        chk("R8 recovered after 128", bus_off_o, 0);
        chk("R8 online", online_o, 1);

        // R11: software-forced bus-off
        set_mode(1'b1); wr(14, 20); wr(15, 255);
        chk("R11 no bus-off in reset", bus_off_o, 0);
        rd(15, v); chk("R11 tx holds 255", v, 255);
        set_mode(1'b0);
        chk("R11 bus_off on release", bus_off_o, 1);
        chk("R11 force pulse", force_reset_o, 1);
        rd(15, v); chk("R11 tx load", v, 127);
        rd(14, v); chk("R11 rx clear", v, 0);
        set_mode(1'b1);
        chk("R11 warn", err_warn_o, 1);
        chk("R11 passive", err_passive_o, 1);

        // R10: clearing bus-off by write, then one bus-free period
        wr(15, 10);
        chk("R10 bus-off cleared", bus_off_o, 0);
        set_mode(1'b0);
        chk("R10 waits", online_o, 0);
        for (int i = 0; i < 10; i++) bitb(1'b1);
        chk("R10 still waits", online_o, 0);
        bitb(1'b1);
        chk("R10 online", online_o, 1);
        rd(15, v); chk("R10 tx kept", v, 10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule